// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block moves an 8-bit word between two ports, A and B, in either direction. Each direction owns a holding register with its own clock. The A-to-B register takes port A on every rising edge of its clock. The B-to-A register takes port B on every rising edge of a second clock. Register capture never pauses, whatever the enable and direction inputs are doing.

An active-low enable and a direction input together pick the port to be driven. They can also pick no port, which is isolation. A per-direction select then chooses what the driven port carries: the live word arriving at the opposite port, or the word held in that direction's register. The block targets synthesis, so each port appears as a separate input bus, output bus and output enable. The surrounding pad logic joins them into a pin.

Reset is an asynchronous active-low input, released synchronously inside each clock domain. A parameter can leave the registers without reset.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab`, the A-to-B register loads `a_in`.
- R2: On each rising edge of `clk_ba`, the B-to-A register loads `b_in`.
- R3: Both registers load on their edges whatever the values of `en_n`, `dir`, `sel_ab` and `sel_ba`.
- R4: With `en_n` = 1 (isolation), `a_oe` and `b_oe` are both 0.
- R5: With `en_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0.
- R6: With `en_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0.
- R7: While `a_oe` = 1, `a_out` equals `b_in` when `sel_ba` = 0 and equals the B-to-A register when `sel_ba` = 1.
- R8: While `b_oe` = 1, `b_out` equals `a_in` when `sel_ab` = 0 and equals the A-to-B register when `sel_ab` = 1.
- R9: `a_oe` and `b_oe` are never 1 together.
- R10: While `rst_n` = 0, both registers hold zero, and this holds when the reset parameter is enabled.
- R11: The live path has no register in it, so a change on the input port reaches the driven output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low drive enable |
| dir | input | 1 | 0 drives port A, 1 drives port B |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 stored B-to-A |
| a_in | input | 8 | Word arriving at port A |
| a_out | output | 8 | Word driven onto port A |
| a_oe | output | 1 | Drive enable of port A |
| b_in | input | 8 | Word arriving at port B |
| b_out | output | 8 | Word driven onto port B |
| b_oe | output | 1 | Drive enable of port B |

## Verification
In each step the bench presents one word to both ports across the capture edges. It then replaces that word with a different one before sampling the outputs. A design that confused stored and live data, or that delayed the live path by a register, therefore shows a mismatch. Random steps include isolation and drive in both directions, and the model registers keep loading in all of them. A design that gated capture with the enable or the direction would then read out a stale word later. Directed cases check that reset clears the stored words while inputs are all ones. They also check that only the expected output enable is raised in each of the three decode states, which catches a swapped direction or a design that drives both ports at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e decode_drive(input logic en_n, input logic dir);
    if (en_n) return DRV_NONE;
    else if (dir) return DRV_B;
    else return DRV_A;
  endfunction
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int WIDTH   = 8,
  parameter bit HAS_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic             cap_en;
  logic [WIDTH-1:0] q_next;
  logic [WIDTH-1:0] q_reg;

  // Capture runs on every edge; the enable is kept explicit.
  assign cap_en = 1'b1;

  always_comb begin
    q_next = q_reg;
    if (cap_en) q_next = d_in;
  end

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_reg <= '0;
        else        q_reg <= q_next;
      end
    end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
        q_reg <= q_next;
      end
    end
  endgenerate

  assign q_out = q_reg;
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] held_ab,
  input  logic [WIDTH-1:0] held_ba,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  drive_e drv;

  always_comb begin
    drv   = decode_drive(en_n, dir);
    a_oe  = (drv == DRV_A);
    b_oe  = (drv == DRV_B);
    a_out = sel_ba ? held_ba : b_in;
    b_out = sel_ab ? held_ab : a_in;
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int WIDTH     = 8,
  parameter bit HAS_RST   = 1'b1,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic             rst_ab_n;
  logic             rst_ba_n;
  logic [WIDTH-1:0] held_ab;
  logic [WIDTH-1:0] held_ba;

  xcvr_rst_sync #(.STAGES(SYNC_LEN)) u_rs_ab (
    .clk(clk_ab), .rst_n(rst_n), .rst_sync_n(rst_ab_n));
  xcvr_rst_sync #(.STAGES(SYNC_LEN)) u_rs_ba (
    .clk(clk_ba), .rst_n(rst_n), .rst_sync_n(rst_ba_n));

  xcvr_hold_reg #(.WIDTH(WIDTH), .HAS_RST(HAS_RST)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_ab_n), .d_in(a_in), .q_out(held_ab));
  xcvr_hold_reg #(.WIDTH(WIDTH), .HAS_RST(HAS_RST)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_ba_n), .d_in(b_in), .q_out(held_ba));

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .en_n(en_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .held_ab(held_ab), .held_ba(held_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst_n,
  input logic             rst_ab_n,
  input logic             rst_ba_n,
  input logic             en_n,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] held_ab,
  input logic [WIDTH-1:0] held_ba,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);
  assert_cap_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_ab_n)
    $past(rst_ab_n) |-> held_ab == $past(a_in));

  assert_cap_ba_R2: assert property (@(posedge clk_ba) disable iff (!rst_ba_n)
    $past(rst_ba_n) |-> held_ba == $past(b_in));

  assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe));

  assert_a_stored_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (a_oe && sel_ba) |-> a_out == held_ba);

  assert_b_stored_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && sel_ab) |-> b_out == held_ab);

  assert_one_side_R9: assert property (@(posedge clk_ab) disable iff (!rst_n)
    $countones({a_oe, b_oe}) <= 1);

  assert_live_R11: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (a_oe && !sel_ba) |-> a_out == b_in);
endmodule

bind dual_reg_xcvr xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .rst_ab_n(rst_ab_n), .rst_ba_n(rst_ba_n),
  .en_n(en_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .b_in(b_in), .held_ab(held_ab), .held_ba(held_ba),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

// File: tb/sim_dual_reg_xcvr.sv
`timescale 1ns/100ps
module sim_dual_reg_xcvr;
  localparam int W = 8;

  logic clk_ab = 1'b0;
  logic clk_ba = 1'b0;
  logic rst_n  = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W-1:0] mdl_ab, mdl_ba;

  always #4 clk_ab = ~clk_ab;
  initial begin
    #2;
    forever #4 clk_ba = ~clk_ba;
  end

  dual_reg_xcvr #(.WIDTH(W)) u0 (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .en_n(en_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  // Reference registers built from R1, R2, R3, R10.
  always @(posedge clk_ab or negedge rst_n)
    if (!rst_n) mdl_ab <= '0; else mdl_ab <= a_in;
  always @(posedge clk_ba or negedge rst_n)
    if (!rst_n) mdl_ba <= '0; else mdl_ba <= b_in;

  function automatic logic exp_a_oe(logic e, logic d);
    return !e && !d;
  endfunction
  function automatic logic exp_b_oe(logic e, logic d);
    return !e && d;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    string oe_req;
    oe_req = en_n ? "R4" : (dir ? "R6" : "R5");
    chk(oe_req, {7'd0, a_oe}, {7'd0, exp_a_oe(en_n, dir)});
    chk("R9", {7'd0, a_oe & b_oe}, 8'd0);
    chk(oe_req, {7'd0, b_oe}, {7'd0, exp_b_oe(en_n, dir)});
    if (a_oe) begin
      if (sel_ba) chk("R7 R2 R3 stored-to-A", a_out, mdl_ba);
      else        chk("R7 R11 live-to-A", a_out, b_in);
    end
    if (b_oe) begin
      if (sel_ab) chk("R8 R1 R3 stored-to-B", b_out, mdl_ab);
      else        chk("R8 R11 live-to-B", b_out, a_in);
    end
  endtask

  // One step: capture word present across both edges, then a new live word.
  task automatic step(logic e, logic d, logic sab, logic sba,
                      logic [W-1:0] cap_a, logic [W-1:0] cap_b,
                      logic [W-1:0] live_a, logic [W-1:0] live_b);
    @(negedge clk_ab);
    #1;
    en_n = e; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = cap_a; b_in = cap_b;
    #6;
    a_in = live_a; b_in = live_b;
    #0.5;
    check_outputs();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R10: inputs at all ones while reset held; stored words must read zero.
    a_in = '1; b_in = '1;
    #30;
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
    #0.5;
    chk("R10 A-side stored", a_out, 8'h00);
    dir = 1'b1; sel_ab = 1'b1;
    #0.5;
    chk("R10 B-side stored", b_out, 8'h00);
    a_in = '0; b_in = '0; en_n = 1'b1;
    #5;
    rst_n = 1'b1;
    repeat (5) @(posedge clk_ab);

    // Directed corners.
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'h11, 8'h22); // R4 isolation, R3 capture
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 8'hC3, 8'h00, 8'hFF); // R8 stored to B
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, 8'hF0, 8'h81, 8'h7E); // R7 stored to A
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h55, 8'hAA); // R11 live to A
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hAA, 8'h55); // R11 live to B

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic e;
      e = ($urandom_range(0, 3) == 0);
      step(e, 1'($urandom), 1'($urandom), 1'($urandom),
           8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule